// File: doc/BRIEF.md
# Shared Video/Processor Memory Controller

This block lets a video accumulator and a microprocessor share one 2K x 8 data RAM, and it also serves the processor's program ROM. A mode input, high while the accumulator is writing integrated video, steers the 11-bit RAM address to the accumulator. While the mode input is low, the address comes from the low eleven processor address bits. Two separate active-low write strobes are produced: one for integration writes from the accumulator and one for processor writes.

From the mode input, the processor's read request, its clock-phase signal and its upper address bits, the block decodes three things. It produces an active-low RAM enable and an active-low ROM enable. It also produces a transceiver direction that points the data bus toward the processor during reads. RAM output is blanked while the processor is in its high clock phase, which frees the shared bus for other drivers.

The RAM and ROM arrays are modelled inside the block. The bidirectional bus is split into a registered read-data port and an output-enable flag. A single flag reports the event in which a processor write collides with an integration write.

Top module: `vpm_ctrl`

## Requirements
- R1: Reset (synchronous, active high) leaves `bus_oe_o` at 0, `bus_rdata_o` at 0 and `clash_o` at 0.
- R2: `mem_addr_o` equals `acc_addr_i` when `vid_mode_i` is 1, and equals `cpu_addr_i[10:0]` when it is 0.
- R3: `vid_wr_n_o` is 0 exactly when `vid_mode_i` and `vid_wr_req_i` are both 1. At that clock edge, `acc_wdata_i` is stored at `acc_addr_i`.
- R4: `cpu_wr_n_o` is 0 exactly when all three of these hold: `vid_mode_i` is 0, `cpu_wr_req_i` is 1, and `cpu_addr_i[15:11]` is 5'b00000 (the RAM window). At that edge, `cpu_wdata_i` is stored at `cpu_addr_i[10:0]`.
- R5: `ram_en_n_o` is 0 when `vid_mode_i` is 1, or when the processor addresses the RAM window with `phase_hi_i` at 0. Otherwise it is 1. In particular, it is held at 1 during processor mode while `phase_hi_i` is 1.
- R6: `rom_en_n_o` is 0 exactly when `vid_mode_i` is 0, `cpu_rd_i` is 1 and `cpu_addr_i[15:11]` is 5'b11111 (the ROM window).
- R7: `to_cpu_o` is 1 exactly when the processor reads in processor mode and either the ROM is enabled, or the RAM window is addressed with `phase_hi_i` at 0.
- R8: A processor read from an enabled RAM or ROM raises `bus_oe_o` on the next cycle, with the addressed byte on `bus_rdata_o`. A RAM read sees the contents from before any write at the same edge. In every other cycle, the next cycle shows `bus_oe_o` at 0 and `bus_rdata_o` at 0.
- R9: The ROM byte at offset k (k = `cpu_addr_i[10:0]`) is ((3*k) mod 256) XOR 0x5A.
- R10: A processor write request to the RAM window, in a cycle where `vid_wr_n_o` is 0, loses: `cpu_wr_n_o` stays 1 and the RAM takes the video byte. In this case `clash_o` rises on the next cycle and stays 1 until reset.
- R11: A processor write request in video mode, or one outside the RAM window, leaves the RAM contents unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| vid_mode_i | input | 1 | 1 = video write mode (accumulator owns address), 0 = processor mode |
| acc_addr_i | input | 11 | Accumulator RAM address |
| acc_wdata_i | input | 8 | Accumulator write byte |
| cpu_addr_i | input | 16 | Processor address |
| cpu_wdata_i | input | 8 | Processor write byte |
| cpu_rd_i | input | 1 | Processor read request |
| phase_hi_i | input | 1 | Processor clock phase 2 high |
| vid_wr_req_i | input | 1 | Accumulator write request |
| cpu_wr_req_i | input | 1 | Processor write request |
| mem_addr_o | output | 11 | Selected RAM address |
| vid_wr_n_o | output | 1 | Integration write strobe, active low |
| cpu_wr_n_o | output | 1 | Processor write strobe, active low |
| ram_en_n_o | output | 1 | RAM enable, active low |
| rom_en_n_o | output | 1 | ROM enable, active low |
| to_cpu_o | output | 1 | Transceiver direction, 1 = toward processor |
| bus_oe_o | output | 1 | Block drives read data this cycle |
| bus_rdata_o | output | 8 | Read data |
| clash_o | output | 1 | Sticky write-collision flag |

## Verification
The bench targets the phase-high window in processor mode. A controller that ignores the phase would leave the RAM enabled and drive stale bytes onto the bus. It also forces collisions between integration and processor writes. A wrong design there would let the processor byte land, fire both strobes together, or drop the flag after one cycle.

Reads at the first and last ROM offsets expose a ROM pattern that is truncated or mis-indexed. A read and a write to the same RAM address on the same edge expose a read path that returns new data instead of old. Processor writes issued in video mode or outside the RAM window are read back afterwards, which would catch a strobe decode that is missing its mode or region term.

// File: rtl/vpm_pkg.sv
package vpm_pkg;

    // Source that owns the registered read-data port in a given cycle
    typedef enum logic [1:0] {
        SRC_NONE = 2'd0,
        SRC_RAM  = 2'd1,
        SRC_ROM  = 2'd2
    } rd_src_e;

    // Combinational decode bundle handed from the decoder to the top
    typedef struct packed {
        logic ram_hit;   // upper address falls in the RAM window
        logic ram_sel;   // RAM enabled this cycle
        logic rom_sel;   // ROM enabled this cycle
        logic cpu_rd;    // processor read of enabled RAM
        logic vid_wr;    // integration write strobe active
        logic cpu_wr;    // processor write strobe active
        logic clash;     // processor write lost to integration write
        logic to_cpu;    // transceiver points toward processor
    } decode_t;

    // Computed ROM pattern: byte k = (k * ROM_MULT) xor ROM_SALT
    localparam int unsigned ROM_MULT = 3;
    localparam int unsigned ROM_SALT = 32'h5A;

endpackage

// File: rtl/vpm_decode.sv
module vpm_decode
    import vpm_pkg::*;
#(
    parameter int TAG_W   = 5,
    parameter int RAM_TAG = 0,
    parameter int ROM_TAG = 31
) (
    input  logic             vid_mode,
    input  logic [TAG_W-1:0] addr_tag,
    input  logic             rd_req,
    input  logic             phase_hi,
    input  logic             vid_wr_req,
    input  logic             cpu_wr_req,
    output decode_t          dec
);

    logic ram_hit;
    logic rom_hit;

    assign ram_hit = (addr_tag == TAG_W'(RAM_TAG));
    assign rom_hit = (addr_tag == TAG_W'(ROM_TAG));

    always_comb begin
        dec         = '0;
        dec.ram_hit = ram_hit;
        // Accumulator owns RAM in video mode; processor loses it in phase high
        dec.ram_sel = vid_mode | (ram_hit & ~phase_hi);
        dec.rom_sel = ~vid_mode & rd_req & rom_hit;
        dec.cpu_rd  = ~vid_mode & rd_req & ram_hit & ~phase_hi;
        dec.vid_wr  = vid_mode & vid_wr_req;
        // Processor strobe only outside video mode, so video always wins
        dec.cpu_wr  = ~vid_mode & cpu_wr_req & ram_hit;
        dec.clash   = dec.vid_wr & cpu_wr_req & ram_hit;
        dec.to_cpu  = dec.rom_sel | dec.cpu_rd;
    end

endmodule

// File: rtl/vpm_ram.sv
module vpm_ram #(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);

    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];
    logic [DW-1:0] rdata_q;

    // Read-first: a read at the write edge returns the old byte
    always_ff @(posedge clk) begin
        if (we) begin
            mem[addr] <= wdata;
        end
        if (rd_en) begin
            rdata_q <= mem[addr];
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/vpm_rom.sv
module vpm_rom
    import vpm_pkg::*;
#(
    parameter int AW = 11,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          rd_en,
    input  logic [AW-1:0] addr,
    output logic [DW-1:0] rdata
);

    logic [DW-1:0] pattern;
    logic [DW-1:0] rdata_q;

    assign pattern = DW'((32'(addr) * ROM_MULT) ^ ROM_SALT);

    always_ff @(posedge clk) begin
        if (rd_en) begin
            rdata_q <= pattern;
        end
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/vpm_ctrl.sv
module vpm_ctrl
    import vpm_pkg::*;
#(
    parameter int MEM_AW  = 11,
    parameter int CPU_AW  = 16,
    parameter int DW      = 8,
    parameter int RAM_TAG = 0,
    parameter int ROM_TAG = 31
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              vid_mode_i,
    input  logic [MEM_AW-1:0] acc_addr_i,
    input  logic [DW-1:0]     acc_wdata_i,
    input  logic [CPU_AW-1:0] cpu_addr_i,
    input  logic [DW-1:0]     cpu_wdata_i,
    input  logic              cpu_rd_i,
    input  logic              phase_hi_i,
    input  logic              vid_wr_req_i,
    input  logic              cpu_wr_req_i,
    output logic [MEM_AW-1:0] mem_addr_o,
    output logic              vid_wr_n_o,
    output logic              cpu_wr_n_o,
    output logic              ram_en_n_o,
    output logic              rom_en_n_o,
    output logic              to_cpu_o,
    output logic              bus_oe_o,
    output logic [DW-1:0]     bus_rdata_o,
    output logic              clash_o
);

    localparam int TAG_W = CPU_AW - MEM_AW;

    decode_t           dec;
    rd_src_e           src_q;
    logic              clash_q;
    logic [MEM_AW-1:0] mem_addr;
    logic [DW-1:0]     wr_byte;
    logic [DW-1:0]     ram_rdata;
    logic [DW-1:0]     rom_rdata;
    logic              ram_hit_w;
    logic              ram_oe_w;
    logic              rom_oe_w;

    vpm_decode #(
        .TAG_W   (TAG_W),
        .RAM_TAG (RAM_TAG),
        .ROM_TAG (ROM_TAG)
    ) u_decode (
        .vid_mode   (vid_mode_i),
        .addr_tag   (cpu_addr_i[CPU_AW-1:MEM_AW]),
        .rd_req     (cpu_rd_i),
        .phase_hi   (phase_hi_i),
        .vid_wr_req (vid_wr_req_i),
        .cpu_wr_req (cpu_wr_req_i),
        .dec        (dec)
    );

    // Address and write-byte selection follow the mode input
    assign mem_addr = vid_mode_i ? acc_addr_i : cpu_addr_i[MEM_AW-1:0];
    assign wr_byte  = dec.vid_wr ? acc_wdata_i : cpu_wdata_i;

    vpm_ram #(
        .AW (MEM_AW),
        .DW (DW)
    ) u_ram (
        .clk   (clk),
        .we    (dec.vid_wr | dec.cpu_wr),
        .rd_en (dec.cpu_rd),
        .addr  (mem_addr),
        .wdata (wr_byte),
        .rdata (ram_rdata)
    );

    vpm_rom #(
        .AW (MEM_AW),
        .DW (DW)
    ) u_rom (
        .clk   (clk),
        .rd_en (dec.rom_sel),
        .addr  (cpu_addr_i[MEM_AW-1:0]),
        .rdata (rom_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q   <= SRC_NONE;
            clash_q <= 1'b0;
        end else begin
            if (dec.rom_sel) begin
                src_q <= SRC_ROM;
            end else if (dec.cpu_rd) begin
                src_q <= SRC_RAM;
            end else begin
                src_q <= SRC_NONE;
            end
            clash_q <= clash_q | dec.clash;
        end
    end

    assign ram_oe_w  = (src_q == SRC_RAM);
    assign rom_oe_w  = (src_q == SRC_ROM);
    assign ram_hit_w = dec.ram_hit;

    always_comb begin
        unique case (src_q)
            SRC_RAM: bus_rdata_o = ram_rdata;
            SRC_ROM: bus_rdata_o = rom_rdata;
            default: bus_rdata_o = '0;
        endcase
    end

    assign mem_addr_o = mem_addr;
    assign vid_wr_n_o = ~dec.vid_wr;
    assign cpu_wr_n_o = ~dec.cpu_wr;
    assign ram_en_n_o = ~dec.ram_sel;
    assign rom_en_n_o = ~dec.rom_sel;
    assign to_cpu_o   = dec.to_cpu;
    assign bus_oe_o   = ram_oe_w | rom_oe_w;
    assign clash_o    = clash_q;

endmodule

// File: rtl/vpm_ctrl_chk.sv
module vpm_ctrl_chk (
    input logic clk,
    input logic rst,
    input logic vid_mode,
    input logic phase_hi,
    input logic cpu_rd,
    input logic cpu_wr_req,
    input logic ram_hit,
    input logic vid_wr_n,
    input logic cpu_wr_n,
    input logic ram_en_n,
    input logic rom_en_n,
    input logic to_cpu,
    input logic bus_oe,
    input logic ram_oe,
    input logic rom_oe,
    input logic clash
);

    // R4 / R10: the two write strobes never fire together
    a_r4_strobes_exclusive: assert property (@(posedge clk) disable iff (rst)
        !(!vid_wr_n && !cpu_wr_n));

    // R5: processor high phase blanks the RAM
    a_r5_phase_blank: assert property (@(posedge clk) disable iff (rst)
        (phase_hi && !vid_mode) |-> ram_en_n);

    // R6: ROM is only enabled for a processor-mode read
    a_r6_rom_needs_read: assert property (@(posedge clk) disable iff (rst)
        !rom_en_n |-> (cpu_rd && !vid_mode));

    // R7: ROM access turns the transceiver toward the processor
    a_r7_rom_direction: assert property (@(posedge clk) disable iff (rst)
        !rom_en_n |-> to_cpu);

    // R8: an enabled ROM read owns the bus on the next cycle
    a_r8_rom_latency: assert property (@(posedge clk) disable iff (rst)
        !rom_en_n |=> (rom_oe && bus_oe));

    // R8: at most one source drives read data
    a_r8_single_source: assert property (@(posedge clk) disable iff (rst)
        $onehot0({ram_oe, rom_oe}));

    // R10: a losing processor write sets the flag
    a_r10_clash_sets: assert property (@(posedge clk) disable iff (rst)
        (!vid_wr_n && cpu_wr_req && ram_hit) |=> clash);

    // R10: the flag is sticky
    a_r10_clash_sticky: assert property (@(posedge clk) disable iff (rst)
        clash |=> clash);

endmodule

bind vpm_ctrl vpm_ctrl_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .vid_mode   (vid_mode_i),
    .phase_hi   (phase_hi_i),
    .cpu_rd     (cpu_rd_i),
    .cpu_wr_req (cpu_wr_req_i),
    .ram_hit    (ram_hit_w),
    .vid_wr_n   (vid_wr_n_o),
    .cpu_wr_n   (cpu_wr_n_o),
    .ram_en_n   (ram_en_n_o),
    .rom_en_n   (rom_en_n_o),
    .to_cpu     (to_cpu_o),
    .bus_oe     (bus_oe_o),
    .ram_oe     (ram_oe_w),
    .rom_oe     (rom_oe_w),
    .clash      (clash_o)
);

// File: tb/tb_vpm_ctrl.sv
module tb_vpm_ctrl;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        vid_mode;
    logic [10:0] acc_addr;
    logic [7:0]  acc_wdata;
    logic [15:0] cpu_addr;
    logic [7:0]  cpu_wdata;
    logic        cpu_rd;
    logic        phase_hi;
    logic        vid_wr_req;
    logic        cpu_wr_req;
    logic [10:0] mem_addr;
    logic        vid_wr_n, cpu_wr_n, ram_en_n, rom_en_n, to_cpu;
    logic        bus_oe;
    logic [7:0]  bus_rdata;
    logic        clash;

    int  checks = 0;
    int  errors = 0;
    bit  done   = 0;

    logic [7:0] shadow [0:2047];
    bit         known  [0:2047];
    bit         exp_clash;

    always #5 clk = ~clk;

    vpm_ctrl dut (
        .clk          (clk),
        .rst          (rst),
        .vid_mode_i   (vid_mode),
        .acc_addr_i   (acc_addr),
        .acc_wdata_i  (acc_wdata),
        .cpu_addr_i   (cpu_addr),
        .cpu_wdata_i  (cpu_wdata),
        .cpu_rd_i     (cpu_rd),
        .phase_hi_i   (phase_hi),
        .vid_wr_req_i (vid_wr_req),
        .cpu_wr_req_i (cpu_wr_req),
        .mem_addr_o   (mem_addr),
        .vid_wr_n_o   (vid_wr_n),
        .cpu_wr_n_o   (cpu_wr_n),
        .ram_en_n_o   (ram_en_n),
        .rom_en_n_o   (rom_en_n),
        .to_cpu_o     (to_cpu),
        .bus_oe_o     (bus_oe),
        .bus_rdata_o  (bus_rdata),
        .clash_o      (clash)
    );

    function automatic logic [7:0] rom_model(input logic [10:0] k);
        int unsigned v;
        v = (32'(k) * 3) % 256;
        return 8'(v) ^ 8'h5A;
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    task automatic idle();
        vid_mode = 0; acc_addr = '0; acc_wdata = '0; cpu_addr = 16'h4000;
        cpu_wdata = '0; cpu_rd = 0; phase_hi = 0; vid_wr_req = 0; cpu_wr_req = 0;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1;
        idle();
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(bus_oe == 0, "R1", "bus_oe after reset", bus_oe, 0);
        chk(bus_rdata == 0, "R1", "rdata after reset", bus_rdata, 0);
        chk(clash == 0, "R1", "clash after reset", clash, 0);
        rst = 0;
        exp_clash = 0;
    endtask

    task automatic cyc(input bit m, input logic [10:0] aa, input logic [7:0] aw,
                       input logic [15:0] ca, input logic [7:0] cw,
                       input bit rd, input bit ph, input bit vr, input bit cr);
        bit         ram_reg, rom_reg, vstb, cstb, e_ram, e_rom, e_dir, e_oe, e_known;
        logic [7:0] e_data;
        logic [10:0] e_addr;
        @(negedge clk);
        vid_mode = m; acc_addr = aa; acc_wdata = aw; cpu_addr = ca; cpu_wdata = cw;
        cpu_rd = rd; phase_hi = ph; vid_wr_req = vr; cpu_wr_req = cr;
        #1;
        ram_reg = (ca[15:11] == 5'b00000);
        rom_reg = (ca[15:11] == 5'b11111);
        e_addr  = m ? aa : ca[10:0];
        vstb    = m & vr;
        cstb    = !m & cr & ram_reg;
        e_ram   = m | (ram_reg & !ph);
        e_rom   = !m & rd & rom_reg;
        e_dir   = e_rom | (!m & rd & ram_reg & !ph);
        chk(mem_addr == e_addr, "R2", "mem_addr", mem_addr, e_addr);
        chk(vid_wr_n == !vstb, "R3", "vid_wr_n", vid_wr_n, !vstb);
        chk(cpu_wr_n == !cstb, "R4", "cpu_wr_n", cpu_wr_n, !cstb);
        chk(ram_en_n == !e_ram, "R5", "ram_en_n", ram_en_n, !e_ram);
        chk(rom_en_n == !e_rom, "R6", "rom_en_n", rom_en_n, !e_rom);
        chk(to_cpu == e_dir, "R7", "to_cpu", to_cpu, e_dir);
        e_known = 1;
        if (e_rom) begin
            e_oe = 1; e_data = rom_model(ca[10:0]);
        end else if (!m && rd && ram_reg && !ph) begin
            e_oe = 1; e_data = shadow[ca[10:0]]; e_known = known[ca[10:0]];
        end else begin
            e_oe = 0; e_data = 8'h00;
        end
        if (vstb) begin
            shadow[aa] = aw; known[aa] = 1;
        end else if (cstb) begin
            shadow[ca[10:0]] = cw; known[ca[10:0]] = 1;
        end
        if (vstb && cr && ram_reg) exp_clash = 1;
        @(posedge clk);
        #1;
        chk(bus_oe == e_oe, "R8", "bus_oe", bus_oe, e_oe);
        if (e_known)
            chk(bus_rdata == e_data, e_rom ? "R9" : "R8", "bus_rdata", bus_rdata, e_data);
        chk(clash == exp_clash, "R10", "clash", clash, exp_clash);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("Result: errors=%0d of %0d checks", errors, checks + 1);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < 2048; i++) known[i] = 0;
        exp_clash = 0;
        idle();
        do_reset();

        // R9 / R6: ROM at first and last offsets
        cyc(0, 0, 0, 16'hF800, 0, 1, 0, 0, 0);
        cyc(0, 0, 0, 16'hFFFF, 0, 1, 1, 0, 0);
        // R4 / R8: processor write then read back
        cyc(0, 0, 0, 16'h0005, 8'h3C, 0, 0, 0, 1);
        cyc(0, 0, 0, 16'h0005, 0, 1, 0, 0, 0);
        // R8: read-first when read and write share an edge
        cyc(0, 0, 0, 16'h0005, 8'hC3, 1, 0, 0, 1);
        cyc(0, 0, 0, 16'h0005, 0, 1, 0, 0, 0);
        // R5: phase high blanks RAM, no data next cycle
        cyc(0, 0, 0, 16'h0005, 0, 1, 1, 0, 0);
        // R3: integration write then processor read
        cyc(1, 11'h005, 8'h99, 16'h0000, 0, 0, 0, 1, 0);
        cyc(0, 0, 0, 16'h0005, 0, 1, 0, 0, 0);
        // R11: processor writes in video mode or outside RAM window ignored
        cyc(1, 11'h010, 0, 16'h0005, 8'h11, 0, 0, 0, 1);
        cyc(0, 0, 0, 16'h4805, 8'h22, 0, 0, 0, 1);
        cyc(0, 0, 0, 16'h0005, 0, 1, 0, 0, 0);
        chk(bus_rdata == 8'h99, "R11", "RAM unchanged", bus_rdata, 8'h99);
        // R10: collision, video wins, flag sticks
        cyc(1, 11'h007, 8'hA1, 16'h0007, 8'h5E, 0, 0, 1, 1);
        cyc(0, 0, 0, 16'h0007, 0, 1, 0, 0, 0);
        chk(bus_rdata == 8'hA1, "R10", "video byte kept", bus_rdata, 8'hA1);
        cyc(0, 0, 0, 16'h4000, 0, 0, 0, 0, 0);

        for (int n = 0; n < 3000; n++) begin
            bit          m, rd, ph, vr, cr;
            logic [10:0] aa;
            logic [15:0] ca;
            int unsigned sel;
            m   = ($urandom % 10) < 3;
            rd  = $urandom % 2;
            ph  = $urandom % 2;
            vr  = $urandom % 2;
            cr  = ($urandom % 10) < 4;
            aa  = {($urandom % 2) ? 7'h7F : 7'h00, 4'($urandom)};
            sel = $urandom % 10;
            if (sel < 5)      ca = {5'b00000, ($urandom % 2) ? 7'h7F : 7'h00, 4'($urandom)};
            else if (sel < 8) ca = {5'b11111, 11'($urandom)};
            else              ca = {5'(1 + $urandom % 30), 11'($urandom)};
            cyc(m, aa, 8'($urandom), ca, 8'($urandom), rd, ph, vr, cr);
        end

        // R1: reset clears the sticky flag
        do_reset();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule